// File: doc/BRIEF.md
# Multi-Mode Multiply-Accumulate Unit

This block multiplies two 32-bit source operands and adds the product to, or subtracts it from, one of four 48-bit accumulators. Three arithmetic modes are chosen by two configuration bits: signed integer, unsigned integer and signed fractional. Operands are either full 32-bit longwords or 16-bit words. Each word comes from the upper or lower half of its source register, chosen by a per-operand select bit.

In integer modes, the product may be scaled by one bit in either direction before it reaches the accumulator. The fill rules for this shift depend on sign mode, operand size, a zero product and product overflow. The block keeps negative, zero and overflow flags, plus one sticky overflow bit for each accumulator. When overflow-mode control is enabled, a set sticky bit freezes its accumulator against further operations.

A command is accepted on a ready/valid handshake. The new accumulator value, the result copy and the flags all appear one clock later.

Top module: `mac_top`

## Requirements
- R1: Mode decode: when `cfgFrac` is 1 the unit works in signed fractional mode, whatever the value of `cfgUnsigned`. Otherwise `cfgUnsigned`=1 selects unsigned integer mode and `cfgUnsigned`=0 selects signed integer mode.
- R2: Operand selection:
  - With `cmdLong`=1, each operand is its whole 32-bit source.
  - With `cmdLong`=0, operand X is bits [31:16] of `cmdRx` when `cmdHiX`=1 and bits [15:0] otherwise. Operand Y is picked the same way by `cmdHiY`.
  - In signed integer mode the 16-bit half is sign-extended; in unsigned mode it is zero-extended.
  - In fractional mode the half is placed in bits [31:16] with zeros below.
- R3: The accumulator value is computed as follows.
  - The accumulator is extended: signed in signed modes, zero-extended in unsigned mode.
  - The scaled product is added when `cmdSub`=0 and subtracted when `cmdSub`=1.
  - The low 48 bits of the sum are written back to the target accumulator.
- R4: Integer scaling is set by `cmdShift`:
  - 2'b00 and 2'b11 leave the product unchanged.
  - 2'b01 doubles the 64-bit product with a zero entering the LSB.
  - 2'b10 halves it. In unsigned mode a zero enters the MSB.
  - In fractional mode `cmdShift` is ignored.
- R5: In signed integer mode, a right shift of the 64-bit product fills its MSB as follows.
  - Word operands: the fill is the product's sign bit, or zero when the product is zero.
  - Longword operands: the fill is the sign bit, or zero when the product is zero or has overflowed (see R7).
- R6: Fractional alignment: the signed 64-bit product of the two 32-bit fractions is doubled and then arithmetically shifted right by 16 bits before accumulation.
- R7: `flagV` is set by an operation that proceeds when either of these holds:
  - A longword integer product falls outside the 40-bit range: signed [-2^39, 2^39), unsigned [0, 2^40).
  - The full sum falls outside the 48-bit range: signed [-2^47, 2^47), unsigned [0, 2^48).
- R8: Each accumulator has one sticky overflow bit. An operation that proceeds on accumulator k sets bit k to that operation's overflow result. No other sticky bit changes, and no bit changes without an accepted command.
- R9: Overflow gating: when `cfgOvfMode`=1 and the target accumulator's sticky bit is set, the accumulator is left unchanged. In that case `resAcc` shows the held value, `flagV` is 1 and the sticky bit stays set. With `cfgOvfMode`=0, or with the sticky bit clear, the operation proceeds.
- R10: `flagN` equals bit 47 of `resAcc`, and `flagZ` is 1 exactly when `resAcc` is zero.
- R11: Handshake and timing:
  - `cmdReady` is low during reset and high from the first clock after reset.
  - A command is accepted when `cmdValid` and `cmdReady` are both high.
  - `resValid` pulses in the cycle after acceptance, together with the updated accumulator, `resAcc` and flags.
  - Without acceptance, no state changes.
- R12: When `cmdAccEn`=0, the command targets accumulator 0 regardless of `cmdAccIdx`.
- R13: Reset clears all accumulators, sticky bits, flags, `resAcc` and `resValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgUnsigned | input | 1 | Unsigned integer select |
| cfgFrac | input | 1 | Signed fractional select |
| cfgOvfMode | input | 1 | Freeze accumulators whose sticky overflow is set |
| cmdValid | input | 1 | Command valid |
| cmdReady | output | 1 | Command ready |
| cmdSub | input | 1 | 1 = subtract product, 0 = add |
| cmdLong | input | 1 | 1 = 32-bit operands, 0 = 16-bit halves |
| cmdHiX | input | 1 | Take upper half of cmdRx for word operations |
| cmdHiY | input | 1 | Take upper half of cmdRy for word operations |
| cmdShift | input | 2 | Product scaling: 01 left, 10 right, else none |
| cmdAccEn | input | 1 | Use cmdAccIdx as the target; 0 targets accumulator 0 |
| cmdAccIdx | input | 2 | Target accumulator index |
| cmdRx | input | 32 | Source register X |
| cmdRy | input | 32 | Source register Y |
| resValid | output | 1 | Result valid pulse |
| resAcc | output | 48 | Value of the target accumulator after the operation |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| stickyOvf | output | 4 | Per-accumulator sticky overflow |
| accAll | output | 192 | All accumulators, accumulator k at bits [48k+47:48k] |

## Verification
A sweep runs every mode, operand size, half-select pair, shift code and add/subtract choice against seven operand values. These include zero, one, all ones, the most negative longword and mixed-sign halves, so the run separates sign extension from zero extension and upper halves from lower halves. The accumulators wrap and overflow freely during the sweep, and a bench model tracks every accumulator and sticky bit. Directed cases use known constants to isolate the right-shift fill rules: an overflowed negative longword with zero fill, against small negative products with sign fill. They also cover the fractional -1 times -1 overflow, a 40-bit product overflow that still fits the accumulator, unsigned underflow, and freezing and release of a sticky accumulator.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    MODE_SINT  = 2'd0,
    MODE_UINT  = 2'd1,
    MODE_SFRAC = 2'd2
  } macMode_e;

  typedef enum logic [1:0] {
    SHF_NONE  = 2'd0,
    SHF_LEFT  = 2'd1,
    SHF_RIGHT = 2'd2,
    SHF_RSVD  = 2'd3
  } macShift_e;

  // strobes from control to datapath
  typedef struct packed {
    macMode_e mode;
    logic     accWe;
  } macStrobe_t;

endpackage

// File: rtl/mac_dp.sv
module mac_dp
  import mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ACC_W   = 48,
  parameter int NUM_ACC = 4,
  parameter int POVF_W  = 40
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  macStrobe_t                   strobe,
  input  logic                         cmdSub,
  input  logic                         cmdLong,
  input  logic                         cmdHiX,
  input  logic                         cmdHiY,
  input  logic [1:0]                   cmdShift,
  input  logic [$clog2(NUM_ACC)-1:0]   tgtIdx,
  input  logic [DATA_W-1:0]            rx,
  input  logic [DATA_W-1:0]            ry,
  output logic [ACC_W-1:0]             sumRes,
  output logic [ACC_W-1:0]             tgtAcc,
  output logic                         ovfNow,
  output logic [NUM_ACC*ACC_W-1:0]     accAll
);

  localparam int HW  = DATA_W / 2;
  localparam int PW  = 2 * DATA_W + 2;   // exact product width incl. sign
  localparam int LW  = 2 * DATA_W;       // product vector that gets shifted
  localparam int SW  = PW + 2;           // sum width
  localparam int FSH = 2 * DATA_W - ACC_W;

  logic isSigned, isFrac;
  assign isSigned = (strobe.mode != MODE_UINT);
  assign isFrac   = (strobe.mode == MODE_SFRAC);

  // operand selection
  logic [HW-1:0]   halfX, halfY;
  logic [DATA_W:0] opX, opY;

  assign halfX = cmdHiX ? rx[DATA_W-1:HW] : rx[HW-1:0];
  assign halfY = cmdHiY ? ry[DATA_W-1:HW] : ry[HW-1:0];

  always_comb begin
    if (cmdLong) begin
      opX = {isSigned & rx[DATA_W-1], rx};
      opY = {isSigned & ry[DATA_W-1], ry};
    end else if (isFrac) begin
      opX = {halfX[HW-1], halfX, {HW{1'b0}}};
      opY = {halfY[HW-1], halfY, {HW{1'b0}}};
    end else begin
      opX = {{(HW+1){isSigned & halfX[HW-1]}}, halfX};
      opY = {{(HW+1){isSigned & halfY[HW-1]}}, halfY};
    end
  end

  // multiply
  logic signed [PW-1:0] wideX, wideY, prod;
  assign wideX = PW'($signed(opX));
  assign wideY = PW'($signed(opY));
  assign prod  = wideX * wideY;

  logic prodOvf;
  logic [PW-POVF_W:0]   upperS;
  logic [PW-POVF_W-1:0] upperU;
  assign upperS = prod[PW-1:POVF_W-1];
  assign upperU = prod[PW-1:POVF_W];
  always_comb begin
    prodOvf = 1'b0;
    if (cmdLong && !isFrac) begin
      if (isSigned) prodOvf = !((&upperS) || !(|upperS));
      else          prodOvf = |upperU;
    end
  end

  // scaling
  logic [LW-1:0]        pLow, rsh;
  logic                 fillBit;
  logic signed [PW-1:0] dbl, addend;

  assign pLow = prod[LW-1:0];
  assign dbl  = prod <<< 1;

  always_comb begin
    if (!isSigned)             fillBit = 1'b0;
    else if (pLow == '0)       fillBit = 1'b0;
    else if (cmdLong && prodOvf) fillBit = 1'b0;
    else                       fillBit = pLow[LW-1];
    rsh = {fillBit, pLow[LW-1:1]};
  end

  always_comb begin
    if (isFrac) begin
      addend = dbl >>> FSH;
    end else begin
      case (cmdShift)
        SHF_LEFT:  addend = dbl;
        SHF_RIGHT: addend = isSigned ? PW'($signed(rsh)) : PW'(rsh);
        default:   addend = prod;
      endcase
    end
  end

  // accumulate
  logic [ACC_W-1:0]     accReg [NUM_ACC];
  logic signed [SW-1:0] accWide, addWide, sum;
  logic [SW-ACC_W:0]    sumTopS;
  logic [SW-ACC_W-1:0]  sumTopU;
  logic                 accOvf;

  assign tgtAcc  = accReg[tgtIdx];
  assign accWide = isSigned ? SW'($signed(tgtAcc)) : SW'(tgtAcc);
  assign addWide = SW'(addend);
  assign sum     = cmdSub ? (accWide - addWide) : (accWide + addWide);
  assign sumTopS = sum[SW-1:ACC_W-1];
  assign sumTopU = sum[SW-1:ACC_W];
  assign accOvf  = isSigned ? !((&sumTopS) || !(|sumTopS)) : (|sumTopU);
  assign sumRes  = sum[ACC_W-1:0];
  assign ovfNow  = prodOvf | accOvf;

  for (genvar g = 0; g < NUM_ACC; g++) begin : gAcc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        accReg[g] <= '0;
      else if (strobe.accWe && (tgtIdx == g))
        accReg[g] <= sumRes;
    end
    assign accAll[g*ACC_W +: ACC_W] = accReg[g];
  end

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int ACC_W   = 48,
  parameter int NUM_ACC = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgUnsigned,
  input  logic                         cfgFrac,
  input  logic                         cfgOvfMode,
  input  logic                         cmdValid,
  output logic                         cmdReady,
  input  logic                         cmdAccEn,
  input  logic [$clog2(NUM_ACC)-1:0]   cmdAccIdx,
  input  logic [ACC_W-1:0]             sumRes,
  input  logic [ACC_W-1:0]             tgtAcc,
  input  logic                         ovfNow,
  output macStrobe_t                   strobe,
  output logic [$clog2(NUM_ACC)-1:0]   tgtIdx,
  output logic                         resValid,
  output logic [ACC_W-1:0]             resAcc,
  output logic                         flagN,
  output logic                         flagZ,
  output logic                         flagV,
  output logic [NUM_ACC-1:0]           stickyOvf
);

  logic readyQ, fire, gated;
  logic [ACC_W-1:0] outVal;
  macMode_e modeSel;

  always_comb begin
    if (cfgFrac)          modeSel = MODE_SFRAC;
    else if (cfgUnsigned) modeSel = MODE_UINT;
    else                  modeSel = MODE_SINT;
  end

  assign tgtIdx   = cmdAccEn ? cmdAccIdx : '0;
  assign cmdReady = readyQ;
  assign fire     = cmdValid & readyQ;
  assign gated    = cfgOvfMode & stickyOvf[tgtIdx];
  assign outVal   = gated ? tgtAcc : sumRes;

  assign strobe.mode  = modeSel;
  assign strobe.accWe = fire & ~gated;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ   <= 1'b0;
      resValid <= 1'b0;
      resAcc   <= '0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
      flagV    <= 1'b0;
    end else begin
      readyQ   <= 1'b1;
      resValid <= fire;
      if (fire) begin
        resAcc <= outVal;
        flagN  <= outVal[ACC_W-1];
        flagZ  <= (outVal == '0);
        flagV  <= gated | ovfNow;
      end
    end
  end

  for (genvar g = 0; g < NUM_ACC; g++) begin : gSticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stickyOvf[g] <= 1'b0;
      else if (fire && !gated && (tgtIdx == g))
        stickyOvf[g] <= ovfNow;
    end
  end

endmodule

// File: rtl/mac_top.sv
module mac_top
  import mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ACC_W   = 48,
  parameter int NUM_ACC = 4,
  parameter int POVF_W  = 40
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgUnsigned,
  input  logic                         cfgFrac,
  input  logic                         cfgOvfMode,
  input  logic                         cmdValid,
  output logic                         cmdReady,
  input  logic                         cmdSub,
  input  logic                         cmdLong,
  input  logic                         cmdHiX,
  input  logic                         cmdHiY,
  input  logic [1:0]                   cmdShift,
  input  logic                         cmdAccEn,
  input  logic [$clog2(NUM_ACC)-1:0]   cmdAccIdx,
  input  logic [DATA_W-1:0]            cmdRx,
  input  logic [DATA_W-1:0]            cmdRy,
  output logic                         resValid,
  output logic [ACC_W-1:0]             resAcc,
  output logic                         flagN,
  output logic                         flagZ,
  output logic                         flagV,
  output logic [NUM_ACC-1:0]           stickyOvf,
  output logic [NUM_ACC*ACC_W-1:0]     accAll
);

  localparam int IDX_W = $clog2(NUM_ACC);

  macStrobe_t       strobe;
  logic [IDX_W-1:0] tgtIdx;
  logic [ACC_W-1:0] sumRes, tgtAcc;
  logic             ovfNow;

  mac_ctrl #(.ACC_W(ACC_W), .NUM_ACC(NUM_ACC)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgUnsigned(cfgUnsigned), .cfgFrac(cfgFrac), .cfgOvfMode(cfgOvfMode),
    .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAccEn(cmdAccEn), .cmdAccIdx(cmdAccIdx),
    .sumRes(sumRes), .tgtAcc(tgtAcc), .ovfNow(ovfNow),
    .strobe(strobe), .tgtIdx(tgtIdx),
    .resValid(resValid), .resAcc(resAcc),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV),
    .stickyOvf(stickyOvf)
  );

  mac_dp #(.DATA_W(DATA_W), .ACC_W(ACC_W), .NUM_ACC(NUM_ACC), .POVF_W(POVF_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdSub(cmdSub), .cmdLong(cmdLong), .cmdHiX(cmdHiX), .cmdHiY(cmdHiY),
    .cmdShift(cmdShift), .tgtIdx(tgtIdx), .rx(cmdRx), .ry(cmdRy),
    .sumRes(sumRes), .tgtAcc(tgtAcc), .ovfNow(ovfNow), .accAll(accAll)
  );

endmodule

// File: rtl/mac_chk.sv
module mac_chk #(
  parameter int ACC_W   = 48,
  parameter int NUM_ACC = 4
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         cfgOvfMode,
  input logic                         cmdValid,
  input logic                         cmdReady,
  input logic                         cmdAccEn,
  input logic [$clog2(NUM_ACC)-1:0]   cmdAccIdx,
  input logic                         resValid,
  input logic [ACC_W-1:0]             resAcc,
  input logic                         flagN,
  input logic                         flagZ,
  input logic                         flagV,
  input logic [NUM_ACC-1:0]           stickyOvf,
  input logic [NUM_ACC*ACC_W-1:0]     accAll
);

  logic fire, gatedNow;
  logic [$clog2(NUM_ACC)-1:0] tIdx;
  assign fire     = cmdValid & cmdReady;
  assign tIdx     = cmdAccEn ? cmdAccIdx : '0;
  assign gatedNow = fire & cfgOvfMode & stickyOvf[tIdx];

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> resValid); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !fire |=> !resValid); // R11
  AST_NOT_READY_IN_RESET: assert property (@(posedge clk)
    !rstN |=> !cmdReady); // R11
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> !resValid); // R13
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    gatedNow |=> ($stable(accAll) && flagV)); // R9
  AST_FLAG_NZ: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ((flagN == resAcc[ACC_W-1]) && (flagZ == (resAcc == '0)))); // R10
  AST_STICKY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !fire |=> $stable(stickyOvf)); // R8
  AST_STICKY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> ($countones(stickyOvf ^ $past(stickyOvf)) <= 1)); // R8
  AST_V_MATCHES_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> (flagV == stickyOvf[$past(tIdx)])); // R7

endmodule

bind mac_top mac_chk #(.ACC_W(ACC_W), .NUM_ACC(NUM_ACC)) uChk (.*);

// File: tb/sim_mac_top.sv
`timescale 1ns/1ps
module sim_mac_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgUnsigned = 1'b0, cfgFrac = 1'b0, cfgOvfMode = 1'b0;
  logic cmdValid = 1'b0, cmdSub = 1'b0, cmdLong = 1'b0, cmdHiX = 1'b0, cmdHiY = 1'b0;
  logic [1:0] cmdShift = 2'd0;
  logic cmdAccEn = 1'b0;
  logic [1:0] cmdAccIdx = 2'd0;
  logic [31:0] cmdRx = '0, cmdRy = '0;
  logic cmdReady, resValid, flagN, flagZ, flagV;
  logic [47:0] resAcc;
  logic [3:0] stickyOvf;
  logic [191:0] accAll;

  int checks = 0;
  int errors = 0;

  logic [47:0] mAcc [4];
  logic [3:0]  mSticky;

  always #10 clk = ~clk;

  mac_top u0 (
    .clk(clk), .rstN(rstN),
    .cfgUnsigned(cfgUnsigned), .cfgFrac(cfgFrac), .cfgOvfMode(cfgOvfMode),
    .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdSub(cmdSub), .cmdLong(cmdLong), .cmdHiX(cmdHiX), .cmdHiY(cmdHiY),
    .cmdShift(cmdShift), .cmdAccEn(cmdAccEn), .cmdAccIdx(cmdAccIdx),
    .cmdRx(cmdRx), .cmdRy(cmdRy),
    .resValid(resValid), .resAcc(resAcc),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV),
    .stickyOvf(stickyOvf), .accAll(accAll)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [47:0] accOf(input int k);
    return accAll[k*48 +: 48];
  endfunction

  // arithmetic model built from the requirements
  task automatic calc(input logic uns, input logic frac, input logic sub,
                      input logic lng, input logic hx, input logic hy,
                      input logic [1:0] shf, input logic [47:0] acc,
                      input logic [31:0] rx, input logic [31:0] ry,
                      output logic [47:0] res, output logic ovf);
    logic sgn;
    logic [15:0] h;
    logic signed [79:0] x, y, p, a, ax, s;
    logic pOvf, aOvf;
    sgn = frac || !uns;
    if (lng) x = sgn ? {{48{rx[31]}}, rx} : {48'd0, rx};
    else begin
      h = hx ? rx[31:16] : rx[15:0];
      if (frac)      x = {{48{h[15]}}, h, 16'd0};
      else if (sgn)  x = {{64{h[15]}}, h};
      else           x = {64'd0, h};
    end
    if (lng) y = sgn ? {{48{ry[31]}}, ry} : {48'd0, ry};
    else begin
      h = hy ? ry[31:16] : ry[15:0];
      if (frac)      y = {{48{h[15]}}, h, 16'd0};
      else if (sgn)  y = {{64{h[15]}}, h};
      else           y = {64'd0, h};
    end
    p = x * y;
    pOvf = 1'b0;
    if (lng && !frac)
      pOvf = sgn ? (p >= (80'sd1 <<< 39) || p < -(80'sd1 <<< 39))
                 : (p >= (80'sd1 <<< 40));
    if (frac) a = (p * 2) >>> 16;
    else if (shf == 2'd1) a = p * 2;
    else if (shf == 2'd2) begin
      if (!sgn) a = p >>> 1;
      else if (p == 0) a = 0;
      else if (lng && pOvf) a = {17'd0, p[63:1]};
      else a = p >>> 1;
    end else a = p;
    ax = sgn ? {{32{acc[47]}}, acc} : {32'd0, acc};
    s = sub ? ax - a : ax + a;
    aOvf = sgn ? (s >= (80'sd1 <<< 47) || s < -(80'sd1 <<< 47))
               : (s < 0 || s >= (80'sd1 <<< 48));
    res = s[47:0];
    ovf = pOvf || aOvf;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cmdValid = 1'b0;
    cfgOvfMode = 1'b0;
    repeat (2) @(negedge clk);
    check("R11", "ready in reset", {63'd0, cmdReady}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "ready after reset", {63'd0, cmdReady}, 64'd1);
    for (int k = 0; k < 4; k++) mAcc[k] = '0;
    mSticky = '0;
  endtask

  task automatic doOp(input logic uns, input logic frac, input logic omc,
                      input logic sub, input logic lng, input logic hx,
                      input logic hy, input logic [1:0] shf, input logic en,
                      input logic [1:0] idx, input logic [31:0] rx,
                      input logic [31:0] ry);
    cfgUnsigned = uns; cfgFrac = frac; cfgOvfMode = omc;
    cmdSub = sub; cmdLong = lng; cmdHiX = hx; cmdHiY = hy; cmdShift = shf;
    cmdAccEn = en; cmdAccIdx = idx; cmdRx = rx; cmdRy = ry;
    cmdValid = 1'b1;
    @(posedge clk);
    #1 cmdValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic expRes(input string tag, input logic [47:0] r,
                        input logic v, input logic [3:0] st);
    check(tag, "resValid", {63'd0, resValid}, 64'd1);
    check(tag, "resAcc", {16'd0, resAcc}, {16'd0, r});
    check("R10", "flagN", {63'd0, flagN}, {63'd0, r[47]});
    check("R10", "flagZ", {63'd0, flagZ}, {63'd0, (r == 48'd0)});
    check("R7", "flagV", {63'd0, flagV}, {63'd0, v});
    check("R8", "sticky", {60'd0, stickyOvf}, {60'd0, st});
  endtask

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_8001;
      5: return 32'h0003_FFFE;
      default: return 32'h1234_ABCD;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R13 reset state
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R13", "resValid", {63'd0, resValid}, 64'd0);
    check("R13", "acc", {63'd0, (accAll == '0)}, 64'd1);
    check("R13", "sticky", {60'd0, stickyOvf}, 64'd0);
    check("R13", "flags", {61'd0, flagN, flagZ, flagV}, 64'd0);
    doReset();

    // Group 1: operand selection, modes, subtract, default index
    doOp(0,0,0, 0,0,1,0, 2'd0, 1,2'd0, 32'h8000_0001, 32'h0000_0003);
    expRes("R2", 48'hFFFF_FFFE_8000, 0, 4'b0000);
    doOp(1,0,0, 0,0,1,0, 2'd0, 1,2'd1, 32'h8000_0001, 32'h0000_0003);
    expRes("R1", 48'h0000_0001_8000, 0, 4'b0000);
    doOp(0,0,0, 0,0,0,0, 2'd0, 1,2'd2, 32'h8000_0001, 32'h0000_0003);
    expRes("R2", 48'h0000_0000_0003, 0, 4'b0000);
    doOp(0,0,0, 1,1,0,0, 2'd0, 1,2'd3, 32'h0000_0002, 32'h0000_0003);
    expRes("R3", 48'hFFFF_FFFF_FFFA, 0, 4'b0000);
    doOp(0,0,0, 0,1,0,0, 2'd0, 0,2'd3, 32'h0000_0001, 32'h0000_0001);
    expRes("R12", 48'hFFFF_FFFE_8001, 0, 4'b0000);
    check("R12", "acc3 untouched", {16'd0, accOf(3)}, {16'd0, 48'hFFFF_FFFF_FFFA});

    // Group 2: scaling fill rules
    doReset();
    doOp(0,0,0, 0,1,0,0, 2'd2, 1,2'd0, 32'h8000_0000, 32'h7FFF_FFFF);
    expRes("R5", 48'h0000_4000_0000, 1, 4'b0001);
    doOp(0,0,0, 0,1,0,0, 2'd2, 1,2'd1, 32'hFFFF_FFFD, 32'h0000_0001);
    expRes("R5", 48'hFFFF_FFFF_FFFE, 0, 4'b0001);
    doOp(0,0,0, 0,0,0,0, 2'd2, 1,2'd2, 32'h0000_FFFD, 32'h0000_0001);
    expRes("R5", 48'hFFFF_FFFF_FFFE, 0, 4'b0001);
    doOp(1,0,0, 0,1,0,0, 2'd2, 1,2'd3, 32'hFFFF_FFFF, 32'h0000_0001);
    expRes("R4", 48'h0000_7FFF_FFFF, 0, 4'b0001);
    doOp(1,0,0, 0,1,0,0, 2'd1, 1,2'd3, 32'h0000_0003, 32'h0000_0001);
    expRes("R4", 48'h0000_8000_0005, 0, 4'b0001);

    // Group 3: fractional alignment and sticky gating
    doReset();
    doOp(0,1,0, 0,1,0,0, 2'd1, 1,2'd0, 32'h4000_0000, 32'h4000_0000);
    expRes("R6", 48'h2000_0000_0000, 0, 4'b0000);
    doOp(0,1,0, 0,0,0,1, 2'd0, 1,2'd1, 32'h0000_4000, 32'h4000_0000);
    expRes("R6", 48'h2000_0000_0000, 0, 4'b0000);
    doOp(0,1,0, 0,1,0,0, 2'd0, 1,2'd2, 32'h8000_0000, 32'h8000_0000);
    expRes("R7", 48'h8000_0000_0000, 1, 4'b0100);
    doOp(0,1,1, 0,1,0,0, 2'd0, 1,2'd2, 32'h4000_0000, 32'h4000_0000);
    expRes("R9", 48'h8000_0000_0000, 1, 4'b0100);
    check("R9", "acc2 held", {16'd0, accOf(2)}, {16'd0, 48'h8000_0000_0000});
    doOp(0,1,1, 0,1,0,0, 2'd0, 1,2'd1, 32'h4000_0000, 32'h4000_0000);
    expRes("R9", 48'h4000_0000_0000, 0, 4'b0100);
    doOp(0,1,0, 0,1,0,0, 2'd0, 1,2'd2, 32'h4000_0000, 32'h4000_0000);
    expRes("R8", 48'hA000_0000_0000, 0, 4'b0000);

    // Group 4: overflow sources and idle
    doReset();
    doOp(0,0,0, 0,1,0,0, 2'd0, 1,2'd0, 32'h0010_0000, 32'h0010_0000);
    expRes("R7", 48'h0100_0000_0000, 1, 4'b0001);
    doOp(0,0,0, 0,0,0,0, 2'd0, 1,2'd1, 32'h0000_8000, 32'h0000_8000);
    expRes("R7", 48'h0000_4000_0000, 0, 4'b0001);
    doOp(1,0,0, 1,1,0,0, 2'd0, 1,2'd2, 32'h0000_0001, 32'h0000_0001);
    expRes("R7", 48'hFFFF_FFFF_FFFF, 1, 4'b0101);
    @(negedge clk);
    check("R11", "idle resValid", {63'd0, resValid}, 64'd0);
    check("R11", "idle acc2", {16'd0, accOf(2)}, {16'd0, 48'hFFFF_FFFF_FFFF});

    // Sweep against the model
    doReset();
    begin
      int n;
      n = 0;
      for (int md = 0; md < 3; md++)
        for (int ln = 0; ln < 2; ln++)
          for (int hs = 0; hs < 4; hs++)
            for (int sh = 0; sh < 4; sh++)
              for (int sb = 0; sb < 2; sb++)
                for (int ix = 0; ix < 7; ix++)
                  for (int iy = 0; iy < 7; iy++) begin
                    logic uns, frc, en;
                    logic [1:0] idx;
                    int t;
                    logic [47:0] r;
                    logic v;
                    uns = (md == 1);
                    frc = (md == 2);
                    idx = 2'(n % 4);
                    en  = (n % 5) != 0;
                    t   = en ? int'(idx) : 0;
                    calc(uns, frc, 1'(sb), 1'(ln), 1'(hs >> 1), 1'(hs), 2'(sh),
                         mAcc[t], pick(ix), pick(iy), r, v);
                    mAcc[t] = r;
                    mSticky[t] = v;
                    doOp(uns, frc, 0, 1'(sb), 1'(ln), 1'(hs >> 1), 1'(hs), 2'(sh),
                         en, idx, pick(ix), pick(iy));
                    expRes("R3", r, v, mSticky);
                    for (int k = 0; k < 4; k++)
                      check("R3", "acc", {16'd0, accOf(k)}, {16'd0, mAcc[k]});
                    n++;
                  end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule